// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets a host controller reach a small file of 8-bit configuration registers over four wires: an active-low select, a serial clock, a data line into the block and a data line out of it. A frame opens with a 7-bit device identifier and a direction flag. In a write frame, a pointer byte follows, then any number of data bytes. Each data byte lands in the register that the pointer names. A read frame carries only the identifier and the flag. After that the block streams registers out, starting at the pointer left by an earlier frame. The pointer steps by one after every complete data byte in either direction, so a burst covers consecutive registers.

All serial inputs are sampled by the system clock through two-flop synchronizers, and edges are found from the synchronized values. The block therefore runs in a single clock domain. The serial clock must be several system clocks slow. The port stays unselected after reset until the select line shows a high-to-low transition. The output data line is split into a value and an enable, and the pad logic outside the block builds the tristate from them.

Top module: `spi_regport`

## Requirements
- R1: After reset release, no frame is decoded and `so_en` stays 0 until `cs_n` is seen going from 1 to 0. A frame begun with `cs_n` already low at reset release changes no register and no pointer.
- R2: The first seven bits of a frame, MSB first, must equal 1001111. Otherwise, the rest of the frame is ignored: no register or pointer changes and `so_en` stays 0.
- R3: Bit 8 of the frame is the direction flag, with 0 for write and 1 for read. In a write frame, bits 9 to 16 load the pointer MSB first, and each later 8-bit group, MSB first, is written to the register that the pointer selects.
- R4: A write frame that ends right after the pointer byte only updates the pointer.
- R5: In a read frame, the first falling serial clock edge after the direction bit sets `so_en` to 1 and drives the MSB of the register at the stored pointer. Each later falling edge drives the next bit, MSB first.
- R6: `so_en` is 0 during every write frame and whenever `cs_n` is high.
- R7: After each complete data byte, the pointer increments by one in both read and write frames.
- R8: Registers exist at pointers 0 to NREG-1 (default 16). A write to a higher pointer is discarded, and a read from one returns 0x00.
- R9: The pointer wraps from 0xFF to 0x00.
- R10: Raising `cs_n` mid-frame drops any partial byte and restarts the bit count. It also disables `so_en`, and the pointer and registers keep their values.
- R11: Reset clears all registers and the pointer to 0, and leaves `so_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock (sampled) |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data value to host |
| so_en | output | 1 | Output enable for `so` (0 = high impedance) |

## Verification
The assertions check four rules on every cycle. The output enable falls after deselection and is never set outside a read frame or before mode selection. The output value changes only on a falling serial clock edge. Outside a pointer load, the pointer moves only by plus one. The register contents, the effect of a rejected identifier, the dropping of a partial byte, the wrap and the out-of-range behaviour can only be seen in the bench scenarios. Each of those scenarios writes a pattern and then reads it back through later frames.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int NREG = 16,
  parameter logic [6:0] DEV_ID = 7'b1001111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_en
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [2:0] PH_ID = 3'd0, PH_PTR = 3'd1, PH_WR = 3'd2,
                         PH_RD = 3'd3, PH_IGN = 3'd4;

  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q;
  logic       sel;
  logic [2:0] phase, cnt;
  logic [7:0] sh, ptr;
  logic [7:0] regs [NREG];

  wire rise   = sck_q[1] & ~sck_q[2];
  wire fall   = ~sck_q[1] & sck_q[2];
  wire active = sel & ~cs_q[1];
  wire [7:0] sh_nx = {sh[6:0], si_q[1]};
  wire in_rng = {1'b0, ptr} < 9'(NREG);
  wire [7:0] rd_byte = in_rng ? regs[ptr[IW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= '0;
      sck_q <= '0;
      si_q  <= '0;
      sel   <= 1'b0;
      phase <= PH_ID;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= '0;
      so    <= 1'b0;
      so_en <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
      if (cs_q[2] & ~cs_q[1]) sel <= 1'b1;
      if (!active) begin
        phase <= PH_ID;
        cnt   <= '0;
        so_en <= 1'b0;
      end else begin
        if (rise) begin
          sh  <= sh_nx;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            case (phase)
              PH_ID:  phase <= (sh_nx[7:1] != DEV_ID) ? PH_IGN :
                               (sh_nx[0] ? PH_RD : PH_PTR);
              PH_PTR: begin ptr <= sh_nx; phase <= PH_WR; end
              PH_WR:  begin
                if (in_rng) regs[ptr[IW-1:0]] <= sh_nx;
                ptr <= ptr + 8'd1;
              end
              PH_RD:  ptr <= ptr + 8'd1;
              default: ;
            endcase
          end
        end
        if (fall && phase == PH_RD) begin
          so_en <= 1'b1;
          so    <= rd_byte[~cnt];
        end
      end
    end
  end
endmodule

module spi_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       cs_s,
  input logic       fall,
  input logic [2:0] phase,
  input logic [7:0] ptr,
  input logic       so,
  input logic       so_en
);
  a_r6_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_en);
  a_r6_en_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_en) |-> phase == 3'd3);
  a_r1_quiet_until_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!so_en && phase == 3'd0));
  a_r5_changes_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(so));
  a_r7_ptr_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr) && $past(phase) != 3'd1) |-> ptr == $past(ptr) + 8'd1);
  a_r2_ignored_silent: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd4 |-> !so_en);
endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .cs_s(cs_q[1]), .fall(fall),
  .phase(phase), .ptr(ptr), .so(so), .so_en(so_en)
);

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam logic [6:0] ID = 7'b1001111;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  logic so, so_en;
  int errors = 0, checks = 0;
  logic [7:0] mreg [16];
  logic [7:0] mptr = 0;
  logic oe_seen;

  spi_regport u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
                  .so(so), .so_en(so_en));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mexp(input logic [7:0] p);
    return (p < 16) ? mreg[p[3:0]] : 8'h00;
  endfunction

  task automatic wclk(input int n); repeat (n) @(posedge clk); endtask

  task automatic xbit(input logic b, output logic r);
    sck = 0; si = b; wclk(HALF);
    r = so;
    if (so_en) oe_seen = 1;
    sck = 1; wclk(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic sel_on;  cs_n = 0; oe_seen = 0; wclk(4*HALF); endtask
  task automatic sel_off; sck = 0; wclk(HALF); cs_n = 1; wclk(4*HALF); endtask

  task automatic wr_frame(input logic [7:0] id, input logic [7:0] p,
                          input int n, input logic [7:0] seed, input bit upd);
    logic [7:0] r;
    sel_on;
    xbyte({id[6:0], 1'b0}, r);
    xbyte(p, r);
    if (upd) mptr = p;
    for (int k = 0; k < n; k++) begin
      xbyte(seed + 8'(k*37), r);
      if (upd) begin
        if (mptr < 16) mreg[mptr[3:0]] = seed + 8'(k*37);
        mptr++;
      end
    end
    sel_off;
    chk("R6 enable during write", int'(oe_seen), 0);
    chk("R6 enable after deselect", int'(so_en), 0);
  endtask

  task automatic rd_frame(input int n, input string tag);
    logic [7:0] r;
    logic fb;
    sel_on;
    xbyte({ID, 1'b1}, r);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, r);
      if (k == 0) chk({tag, " R5 enable"}, int'(so_en), 1);
      chk({tag, " R5 data"}, int'(r), int'(mexp(mptr)));
      mptr++;
    end
    sel_off;
    chk({tag, " R6 enable off"}, int'(so_en), 0);
    fb = 0;
  endtask

  initial begin
    logic [7:0] r;
    logic fb;
    for (int i = 0; i < 16; i++) mreg[i] = 0;
    void'($urandom(32'h5eed1234));
    wclk(5);
    chk("R11 enable at reset", int'(so_en), 0);
    cs_n = 0;
    wclk(5);
    rst_n = 1;
    wclk(20);
    // R1: frame with select already low at reset release is not decoded
    oe_seen = 0;
    xbyte({ID, 1'b0}, r); xbyte(8'h03, r); xbyte(8'h5A, r);
    chk("R1 no enable before select", int'(oe_seen), 0);
    sel_off;
    rd_frame(4, "R11 R1 reset contents");
    // R3 R7 write burst then read burst
    wr_frame(ID, 8'h02, 4, 8'h11, 1);
    wr_frame(ID, 8'h02, 0, 8'h00, 1);  // R4 pointer only
    rd_frame(4, "R3 R7 R4 burst");
    // R2 bad identifier
    wr_frame(7'b1001110, 8'h07, 2, 8'hEE, 0);
    rd_frame(1, "R2 bad id");
    // R9 wrap and R8 out of range
    wr_frame(ID, 8'hFE, 3, 8'h40, 1);
    wr_frame(ID, 8'hFE, 0, 8'h00, 1);
    rd_frame(3, "R9 R8 wrap");
    wr_frame(ID, 8'h0F, 0, 8'h00, 1);
    rd_frame(2, "R8 edge");
    // R10 abort mid-byte
    wr_frame(ID, 8'h05, 0, 8'h00, 1);
    sel_on;
    xbyte({ID, 1'b0}, r); xbyte(8'h05, r);
    for (int i = 0; i < 4; i++) xbit(1'b1, fb);
    sel_off;
    mptr = 8'h05;
    rd_frame(1, "R10 abort");
    sel_on;
    xbyte({ID, 1'b1}, r);
    for (int i = 0; i < 3; i++) xbit(1'b0, fb);
    sel_off;
    chk("R10 enable after read abort", int'(so_en), 0);
    rd_frame(1, "R10 ptr kept");
    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] p;
      p = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
      case ($urandom % 3)
        0: wr_frame(ID, p, 1 + $urandom % 3, 8'($urandom), 1);
        1: begin wr_frame(ID, p, 0, 8'h00, 1); rd_frame(1 + $urandom % 3, "R7 random"); end
        default: wr_frame(7'($urandom | 1), p, 2, 8'($urandom), 0);
      endcase
    end
    wr_frame(ID, 8'h00, 0, 8'h00, 1);
    rd_frame(16, "R3 final sweep");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule